// File: doc/BRIEF.md
# Wireless Coexistence Slot Arbiter

This block decides, slot by slot, whether a neighbouring Bluetooth radio or the local WLAN MAC owns the shared 2.4 GHz medium. The Bluetooth radio raises an asynchronous request line for each transmit or receive slot it wants. In three-wire operation it also drives an asynchronous priority line. The arbiter brings both lines into its clock domain and compares them with the MAC's busy indication. It answers the radio with a deny line: high blocks the slot. It answers the MAC with a hold-off line: high means the radio holds the medium and the MAC must defer.

Configuration pins choose two-wire or three-wire signalling. They also set whether a high-priority slot may preempt WLAN traffic and how many clocks after the request edge the priority line is sampled. An antenna-override pair drives the antenna-select output directly and bypasses the arbitration result. Every port is a plain level signal. There is no data stream, so no valid/ready handshake and no back-pressure exists at the block's edge.

Top module: `coex_arbiter`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, bt_deny, mac_hold and ant_sel are all 0.
- R2: Each asynchronous Bluetooth input passes through two synchroniser flops. A rising bt_req_a first shows on the outputs after the third rising clock edge following the change.
- R3: After the synchronised request rises, the priority line is captured on the cfg_prio_dly-th clock (0 = the first clock the request is seen). The captured value is kept until the request falls. Before capture the slot is treated as normal priority.
- R4: With cfg_three_wire = 0 the priority line has no effect. A request is denied (bt_deny = 1, mac_hold = 0) while wl_busy = 1, and granted (bt_deny = 0, mac_hold = 1) while wl_busy = 0.
- R5: With cfg_three_wire = 1, a normal-priority request (captured priority 0) is denied while wl_busy = 1 and granted while wl_busy = 0. bt_deny and mac_hold are never both 1.
- R6: With cfg_three_wire = 1 and cfg_prio_preempt = 1, a request with captured priority 1 is granted (bt_deny = 0, mac_hold = 1) even while wl_busy = 1.
- R7: With cfg_prio_preempt = 0, a high-priority request is handled exactly like a normal one.
- R8: bt_deny is 0 one clock after wl_busy falls, or one clock after the synchronised request falls.
- R9: With cfg_ant_ovr = 1, ant_sel equals cfg_ant_val one clock later in either mode. With cfg_ant_ovr = 0, ant_sel (1 = antenna to Bluetooth) follows mac_hold.
- R10: With no request present, bt_deny and mac_hold are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bt_req_a | input | 1 | Bluetooth slot request, asynchronous |
| bt_prio_a | input | 1 | Bluetooth slot priority, asynchronous, 1 = high |
| wl_busy | input | 1 | MAC is transmitting or receiving |
| cfg_three_wire | input | 1 | 1 = three-wire signalling, 0 = two-wire |
| cfg_prio_preempt | input | 1 | 1 = high-priority slots preempt WLAN |
| cfg_prio_dly | input | DLY_W | Clocks from request edge to priority capture |
| cfg_ant_ovr | input | 1 | Antenna override enable |
| cfg_ant_val | input | 1 | Antenna select value under override |
| bt_deny | output | 1 | To Bluetooth: 1 = slot blocked |
| mac_hold | output | 1 | To MAC: 1 = Bluetooth owns the medium |
| ant_sel | output | 1 | Antenna select, 1 = Bluetooth side |

## Verification
The embedded properties check on every cycle the rules that hold one clock at a time. These are: deny-while-busy in two-wire mode, preemption by a captured high priority, release of the deny line, mutual exclusion of deny and hold, idle quiet, the antenna override, and the stability of a captured priority. Only the bench's scenarios can show the end-to-end latency through the synchronisers and the exact capture clock set by cfg_prio_dly. They also show that a priority change after capture is ignored, and that mode and policy combinations line up with a reference model over random slots.

// File: rtl/coex_pkg.sv
package coex_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_DENY  = 2'd1,
    SLOT_GRANT = 2'd2
  } slot_e;
endpackage

// File: rtl/coex_sync.sv
module coex_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[LAST];
endmodule

// File: rtl/coex_prio_sampler.sv
module coex_prio_sampler #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_s,
  input  logic             prio_s,
  input  logic [DLY_W-1:0] dly,
  output logic             prio_ok,
  output logic             prio_hi
);
  logic             req_q;
  logic             armed;
  logic [DLY_W-1:0] cnt;
  logic             rise;

  assign rise = req_s && !req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_s) begin
      prio_ok <= 1'b0;
      prio_hi <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
    end else if (rise) begin
      if (dly == '0) begin
        prio_ok <= 1'b1;
        prio_hi <= prio_s;
      end else begin
        armed <= 1'b1;
        cnt   <= {{(DLY_W-1){1'b0}}, 1'b1};
      end
    end else if (armed && !prio_ok) begin
      if (cnt == dly) begin
        prio_ok <= 1'b1;
        prio_hi <= prio_s;
        armed   <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: once captured, the priority stays put for the slot
  a_r3_prio_held: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_ok && $past(prio_ok)) |-> (prio_hi == $past(prio_hi)));
endmodule

// File: rtl/coex_decide.sv
module coex_decide
  import coex_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic prio_ok_i,
  input  logic prio_hi_i,
  input  logic wl_busy_i,
  input  logic three_wire_i,
  input  logic preempt_i,
  input  logic ant_ovr_i,
  input  logic ant_val_i,
  output logic bt_deny_o,
  output logic mac_hold_o,
  output logic ant_sel_o
);
  slot_e slot;
  logic  high_slot;

  assign high_slot = three_wire_i && preempt_i && prio_ok_i && prio_hi_i;

  always_comb begin
    if (!req_i)                      slot = SLOT_IDLE;
    else if (high_slot)              slot = SLOT_GRANT;
    else if (wl_busy_i)              slot = SLOT_DENY;
    else                             slot = SLOT_GRANT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bt_deny_o  <= 1'b0;
      mac_hold_o <= 1'b0;
      ant_sel_o  <= 1'b0;
    end else begin
      bt_deny_o  <= (slot == SLOT_DENY);
      mac_hold_o <= (slot == SLOT_GRANT);
      ant_sel_o  <= ant_ovr_i ? ant_val_i : (slot == SLOT_GRANT);
    end
  end

  // R4: two-wire request meets busy WLAN -> denied
  a_r4_deny_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && wl_busy_i && !three_wire_i) |=> (bt_deny_o && !mac_hold_o));
  // R5: deny and hold never together
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bt_deny_o && mac_hold_o));
  // R6: captured high priority preempts
  a_r6_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && three_wire_i && preempt_i && prio_ok_i && prio_hi_i) |=> (!bt_deny_o && mac_hold_o));
  // R8: deny released one clock after busy or request ends
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_i || !wl_busy_i) |=> !bt_deny_o);
  // R9: override drives antenna select
  a_r9_ant_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    ant_ovr_i |=> (ant_sel_o == $past(ant_val_i)));
  // R10: no request, both lines quiet
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!bt_deny_o && !mac_hold_o));
endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter #(
  parameter int DLY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bt_req_a,
  input  logic             bt_prio_a,
  input  logic             wl_busy,
  input  logic             cfg_three_wire,
  input  logic             cfg_prio_preempt,
  input  logic [DLY_W-1:0] cfg_prio_dly,
  input  logic             cfg_ant_ovr,
  input  logic             cfg_ant_val,
  output logic             bt_deny,
  output logic             mac_hold,
  output logic             ant_sel
);
  localparam int NUM_ASYNC = 2;

  logic [NUM_ASYNC-1:0] bt_sync;
  logic                 req_s;
  logic                 prio_s;
  logic                 prio_ok;
  logic                 prio_hi;

  coex_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({bt_prio_a, bt_req_a}),
    .q_sync  (bt_sync)
  );

  assign req_s  = bt_sync[0];
  assign prio_s = bt_sync[1];

  coex_prio_sampler #(.DLY_W(DLY_W)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_s   (req_s),
    .prio_s  (prio_s),
    .dly     (cfg_prio_dly),
    .prio_ok (prio_ok),
    .prio_hi (prio_hi)
  );

  coex_decide u_decide (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_s),
    .prio_ok_i    (prio_ok),
    .prio_hi_i    (prio_hi),
    .wl_busy_i    (wl_busy),
    .three_wire_i (cfg_three_wire),
    .preempt_i    (cfg_prio_preempt),
    .ant_ovr_i    (cfg_ant_ovr),
    .ant_val_i    (cfg_ant_val),
    .bt_deny_o    (bt_deny),
    .mac_hold_o   (mac_hold),
    .ant_sel_o    (ant_sel)
  );
endmodule

// File: tb/coex_arbiter_tb.sv
module coex_arbiter_tb_top;
  localparam int DLY_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bt_req_a, bt_prio_a, wl_busy;
  logic             cfg_three_wire, cfg_prio_preempt, cfg_ant_ovr, cfg_ant_val;
  logic [DLY_W-1:0] cfg_prio_dly;
  logic             bt_deny, mac_hold, ant_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  coex_arbiter #(.DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bt_req_a(bt_req_a), .bt_prio_a(bt_prio_a),
    .wl_busy(wl_busy), .cfg_three_wire(cfg_three_wire),
    .cfg_prio_preempt(cfg_prio_preempt), .cfg_prio_dly(cfg_prio_dly),
    .cfg_ant_ovr(cfg_ant_ovr), .cfg_ant_val(cfg_ant_val),
    .bt_deny(bt_deny), .mac_hold(mac_hold), .ant_sel(ant_sel)
  );

  // step to the falling edge after the next rising edge
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {deny,hold,ant} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // {deny, hold}
  function automatic logic [1:0] model(input logic three, input logic pre,
                                       input logic prio, input logic busy, input logic req);
    if (!req) return 2'b00;
    if (three && pre && prio) return 2'b01;
    return busy ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [2:0] full(input logic [1:0] dh, input logic ovr, input logic val);
    return {dh, ovr ? val : dh[0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd5519;
    void'($urandom(seed));
    rst_n = 1'b0; bt_req_a = 1'b0; bt_prio_a = 1'b0; wl_busy = 1'b0;
    cfg_three_wire = 1'b0; cfg_prio_preempt = 1'b0; cfg_prio_dly = '0;
    cfg_ant_ovr = 1'b0; cfg_ant_val = 1'b0;
    #1;
    tick(3);
    check("R1 in reset", {bt_deny, mac_hold, ant_sel}, 3'b000);
    rst_n = 1'b1;
    tick(1);
    check("R1 after reset", {bt_deny, mac_hold, ant_sel}, 3'b000);

    // R2: latency through two synchroniser flops plus output register
    bt_req_a = 1'b1;
    tick(2);
    check("R2 not yet after two edges", {bt_deny, mac_hold, ant_sel}, 3'b000);
    tick(1);
    check("R2 grant on third edge", {bt_deny, mac_hold, ant_sel}, 3'b011);
    // R8: request drop releases after sync + one clock
    wl_busy = 1'b1;
    tick(1);
    check("R4 busy denies two-wire", {bt_deny, mac_hold, ant_sel}, 3'b100);
    bt_req_a = 1'b0;
    tick(3);
    check("R8 deny drops after request falls", {bt_deny, mac_hold, ant_sel}, 3'b000);

    // R3: capture clock set by cfg_prio_dly = 5
    cfg_three_wire = 1'b1; cfg_prio_preempt = 1'b1; cfg_prio_dly = 4'd5;
    bt_prio_a = 1'b1; wl_busy = 1'b1;
    tick(2);
    bt_req_a = 1'b1;
    tick(8);
    check("R3 normal until capture", {bt_deny, mac_hold, ant_sel}, 3'b100);
    tick(1);
    check("R3 R6 preempt after capture", {bt_deny, mac_hold, ant_sel}, 3'b011);
    bt_prio_a = 1'b0;
    tick(5);
    check("R3 priority held for slot", {bt_deny, mac_hold, ant_sel}, 3'b011);
    cfg_prio_preempt = 1'b0;
    tick(1);
    check("R7 policy off treats high as normal", {bt_deny, mac_hold, ant_sel}, 3'b100);
    // R8: busy ending releases deny in one clock
    wl_busy = 1'b0;
    tick(1);
    check("R8 deny drops after busy ends", {bt_deny, mac_hold, ant_sel}, 3'b011);
    bt_req_a = 1'b0;
    tick(4);
    check("R10 idle quiet", {bt_deny, mac_hold, ant_sel}, 3'b000);
    cfg_ant_ovr = 1'b1; cfg_ant_val = 1'b1;
    tick(1);
    check("R9 override with no request", {bt_deny, mac_hold, ant_sel}, 3'b001);
    cfg_ant_ovr = 1'b0; cfg_ant_val = 1'b0;

    // random slots against the model
    for (int t = 0; t < 60; t++) begin
      logic three, pre, prio, busy, ovr, val, prio2;
      logic [DLY_W-1:0] dly;
      three = 1'($urandom()); pre = 1'($urandom()); prio = 1'($urandom());
      busy = 1'($urandom()); ovr = 1'($urandom()); val = 1'($urandom());
      dly = DLY_W'($urandom_range(0, 6));
      cfg_three_wire = three; cfg_prio_preempt = pre; cfg_prio_dly = dly;
      cfg_ant_ovr = ovr; cfg_ant_val = val; bt_prio_a = prio; wl_busy = busy;
      bt_req_a = 1'b0;
      tick(4);
      check("R10 R9 idle slot", {bt_deny, mac_hold, ant_sel}, full(model(three, pre, prio, busy, 1'b0), ovr, val));
      bt_req_a = 1'b1;
      tick(int'(dly) + 5);
      check(three ? "R5 R6 three-wire slot" : "R4 two-wire slot",
            {bt_deny, mac_hold, ant_sel}, full(model(three, pre, prio, busy, 1'b1), ovr, val));
      prio2 = ~prio;
      bt_prio_a = prio2;
      tick(4);
      check("R3 R4 late priority change ignored", {bt_deny, mac_hold, ant_sel},
            full(model(three, pre, prio, busy, 1'b1), ovr, val));
      wl_busy = 1'b0;
      tick(1);
      check("R8 busy release", {bt_deny, mac_hold, ant_sel}, full(model(three, pre, prio, 1'b0, 1'b1), ovr, val));
      bt_req_a = 1'b0;
      tick(3);
      check("R8 R10 request release", {bt_deny, mac_hold, ant_sel}, full(2'b00, ovr, val));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule